// File: doc/BRIEF.md
# Three-Operand Signed Adder with Overflow Detection

This block adds three 64-bit two's-complement operands in a single operation. It returns the sum wrapped to 64 bits, together with a flag that reports signed overflow. The flag is raised when the mathematically exact sum cannot be represented as a signed 64-bit value. Each operand is widened by two guard bits, so the exact sum can never wrap. A carry-save layer folds the three widened operands into two vectors, and a single carry-propagate adder then forms the exact wide sum. The flag is read from the upper bits of that wide sum.

A mode input selects two-operand addition. In that mode the third operand is forced to zero, and overflow follows the familiar two-input rule: the operands share a sign and the result sign differs from it. A request is marked by a valid strobe. Results are registered and appear, with their own valid strobe, one clock after the request. Between requests the outputs hold their last value.

Top module: `tri_add_ovf`

## Requirements
- R1: Once reset has been applied and the clock has run, out_valid, sum and ovf are all 0.
- R2: With two_op = 0, sum equals the low 64 bits of op_a + op_b + op_c. This is addition modulo 2^64.
- R3: With two_op = 0, ovf is 1 exactly when the exact sum of the three signed operands is below -2^63 or above 2^63-1.
- R4: With two_op = 1, op_c has no effect. sum equals op_a + op_b modulo 2^64.
- R5: With two_op = 1, ovf is 1 exactly when op_a and op_b have the same sign bit (bit 63) and the sign bit of sum differs from it.
- R6: out_valid is 1 in the cycle that follows a clock edge sampling in_valid = 1. In that same cycle, sum and ovf show the result for the operands sampled at that edge. out_valid is 0 after an edge that samples in_valid = 0.
- R7: While in_valid = 0, sum and ovf keep their previous values, whatever happens on the operand and mode inputs.
- R8: The wrapped sum does not depend on the order of the operands. Any permutation of op_a, op_b and op_c gives the same sum and the same ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| in_valid | input | 1 | Request strobe; operands and mode are sampled on this edge |
| two_op | input | 1 | 1 selects two-operand addition (op_c ignored) |
| op_a | input | 64 | First signed operand |
| op_b | input | 64 | Second signed operand |
| op_c | input | 64 | Third signed operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| sum | output | 64 | Sum wrapped to 64 bits |
| ovf | output | 1 | Signed overflow flag |

## Verification
Every result (sum, ovf and out_valid) is due exactly one clock after the edge that samples in_valid high. There is one register between the operand pins and the outputs. The bench changes inputs on the falling edge, lets one rising edge capture them, and samples all three outputs on the next falling edge. It samples out_valid once more a cycle later to confirm it has dropped. The hold checks change every input while in_valid is low and wait several edges before comparing against the earlier result.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;

  // Guard bits appended above the operand width so the exact sum of
  // three signed operands can never wrap.
  localparam int GUARD_BITS = 2;

  // Number of bits at the top of the exact sum that must all agree
  // for the result to fit in the operand width.
  localparam int RANGE_BITS = GUARD_BITS + 1;

  typedef enum logic {
    MODE_THREE = 1'b0,
    MODE_TWO   = 1'b1
  } add_mode_e;

  // Two-input sign rule: same operand signs, different result sign.
  function automatic logic sign_rule_ovf(input logic sa, input logic sb,
                                         input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/csa_layer.sv
// One layer of 3:2 carry-save compression across XW bit columns.
// The carry vector is returned already shifted left by one column.
module csa_layer #(
  parameter int XW = 66
) (
  input  logic [XW-1:0] in_x,
  input  logic [XW-1:0] in_y,
  input  logic [XW-1:0] in_z,
  output logic [XW-1:0] part_sum,
  output logic [XW-1:0] part_cy
);

  assign part_cy[0] = 1'b0;

  for (genvar i = 0; i < XW; i++) begin : g_col
    assign part_sum[i] = in_x[i] ^ in_y[i] ^ in_z[i];
    if (i < XW - 1) begin : g_cy
      assign part_cy[i+1] = (in_x[i] & in_y[i]) | (in_x[i] & in_z[i]) |
                            (in_y[i] & in_z[i]);
    end
  end

endmodule

// File: rtl/wide_adder.sv
// Sign-extends the operands, compresses them and forms the exact sum.
module wide_adder #(
  parameter int W  = 64,
  parameter int XW = W + tri_add_pkg::GUARD_BITS
) (
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [W-1:0]  opnd_c,
  input  logic          zero_c,
  output logic [XW-1:0] exact
);

  localparam int EXT = XW - W;

  logic [XW-1:0] ext_a;
  logic [XW-1:0] ext_b;
  logic [XW-1:0] ext_c;
  logic [W-1:0]  gated_c;
  logic [XW-1:0] cs_sum;
  logic [XW-1:0] cs_cy;

  always_comb begin
    gated_c = zero_c ? '0 : opnd_c;
    ext_a   = {{EXT{opnd_a[W-1]}}, opnd_a};
    ext_b   = {{EXT{opnd_b[W-1]}}, opnd_b};
    ext_c   = {{EXT{gated_c[W-1]}}, gated_c};
  end

  csa_layer #(.XW(XW)) u_csa (
    .in_x     (ext_a),
    .in_y     (ext_b),
    .in_z     (ext_c),
    .part_sum (cs_sum),
    .part_cy  (cs_cy)
  );

  assign exact = cs_sum + cs_cy;

  // R2: the compressed path agrees with a direct modular sum
  always_comb begin
    assert_csa_matches_R2 : assert (exact[W-1:0] == opnd_a + opnd_b + gated_c)
      else $error("csa path disagrees with direct sum");
  end

endmodule

// File: rtl/ovf_detect.sv
// Overflow decision: wide range test for three operands, sign rule for two.
module ovf_detect #(
  parameter int W  = 64,
  parameter int XW = W + tri_add_pkg::GUARD_BITS
) (
  input  logic             two_op,
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [XW-W:0]    top_bits,
  output logic             ovf
);

  import tri_add_pkg::*;

  localparam int TB = XW - W + 1;

  logic wide_ovf;
  logic sign_ovf;

  always_comb begin
    wide_ovf = !((top_bits == {TB{1'b0}}) || (top_bits == {TB{1'b1}}));
    sign_ovf = sign_rule_ovf(sign_a, sign_b, top_bits[0]);
    ovf      = (add_mode_e'(two_op) == MODE_TWO) ? sign_ovf : wide_ovf;
  end

  // R5: with the third operand zeroed, the sign rule and range test agree
  always_comb begin
    if (two_op) begin
      assert_two_op_agree_R5 : assert (wide_ovf == sign_ovf)
        else $error("two-operand overflow rules disagree");
    end
  end

endmodule

// File: rtl/tri_add_ovf.sv
module tri_add_ovf #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         two_op,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic         out_valid,
  output logic [W-1:0] sum,
  output logic         ovf
);

  localparam int XW = W + tri_add_pkg::GUARD_BITS;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Datapath
  logic [XW-1:0] exact;
  logic          ovf_c;

  wide_adder #(.W(W), .XW(XW)) u_add (
    .opnd_a (op_a),
    .opnd_b (op_b),
    .opnd_c (op_c),
    .zero_c (two_op),
    .exact  (exact)
  );

  ovf_detect #(.W(W), .XW(XW)) u_ovf (
    .two_op   (two_op),
    .sign_a   (op_a[W-1]),
    .sign_b   (op_b[W-1]),
    .top_bits (exact[XW-1:W-1]),
    .ovf      (ovf_c)
  );

  // Next state
  logic         valid_d, valid_q;
  logic [W-1:0] sum_d,   sum_q;
  logic         ovf_d,   ovf_q;

  always_comb begin
    valid_d = in_valid;
    sum_d   = sum_q;
    ovf_d   = ovf_q;
    if (in_valid) begin
      sum_d = exact[W-1:0];
      ovf_d = ovf_c;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      sum_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      sum_q   <= sum_d;
      ovf_q   <= ovf_d;
    end
  end

  assign out_valid = valid_q;
  assign sum       = sum_q;
  assign ovf       = ovf_q;

  // Checker-side range reference for the three-operand flag
  logic signed [XW-1:0] ref_total;
  logic                 ref_out_of_range;
  always_comb begin
    ref_total = XW'($signed(op_a)) + XW'($signed(op_b)) + XW'($signed(op_c));
    ref_out_of_range = (ref_total > XW'($signed({1'b0, {(W-1){1'b1}}}))) ||
                       (ref_total < XW'($signed({1'b1, {(W-1){1'b0}}})));
  end

  assert_latency_R6 : assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid)
    else $error("out_valid missing after request");

  assert_idle_R6 : assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid)
    else $error("out_valid without request");

  assert_hold_R7 : assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> ($stable(sum) && $stable(ovf)))
    else $error("outputs changed without request");

  assert_sum_R2 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !two_op) |=> (sum == $past(op_a + op_b + op_c)))
    else $error("three-operand sum wrong");

  assert_ignore_c_R4 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && two_op) |=> (sum == $past(op_a + op_b)))
    else $error("third operand leaked into two-operand sum");

  assert_range_R3 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !two_op) |=> (ovf == $past(ref_out_of_range)))
    else $error("three-operand overflow flag wrong");

endmodule

// File: tb/tri_add_ovf_bench.sv
module tri_add_ovf_bench;

  localparam int W = 64;
  localparam logic [W-1:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [W-1:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [W-1:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         two_op = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] op_c = '0;
  logic         out_valid;
  logic [W-1:0] sum;
  logic         ovf;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  tri_add_ovf #(.W(W)) u_tri_add_ovf (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .two_op (two_op),
    .op_a (op_a), .op_b (op_b), .op_c (op_c),
    .out_valid (out_valid), .sum (sum), .ovf (ovf)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference built from the requirements: exact 66-bit arithmetic
  task automatic expect_of(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] c, input logic two,
                           output logic [W-1:0] s, output logic o);
    logic signed [W+1:0] t;
    t = $signed({{2{a[W-1]}}, a}) + $signed({{2{b[W-1]}}, b});
    if (!two) t = t + $signed({{2{c[W-1]}}, c});
    s = t[W-1:0];
    o = (t > $signed({2'b00, MAXV})) || (t < $signed({2'b11, MINV}));
  endtask

  // Issue one request and check its result one cycle later
  task automatic run_op(input string req, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] c,
                        input logic two);
    logic [W-1:0] es;
    logic eo;
    expect_of(a, b, c, two, es, eo);
    @(negedge clk);
    op_a = a; op_b = b; op_c = c; two_op = two; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "out_valid", {63'd0, out_valid}, 64'd1);
    check(req, "sum", sum, es);
    check(req, "ovf", {63'd0, ovf}, {63'd0, eo});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "out_valid", {63'd0, out_valid}, 64'd0);
    check("R1", "sum", sum, 64'd0);
    check("R1", "ovf", {63'd0, ovf}, 64'd0);
  endtask

  task automatic t_three_sum;
    run_op("R2", 64'd5, 64'd7, 64'd11, 1'b0);
    run_op("R2", NEG1, 64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
    run_op("R2", 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F,
           64'hF000_0000_0000_0001, 1'b0);
  endtask

  task automatic t_three_ovf;
    run_op("R3", MINV, MINV, MINV, 1'b0);          // far below range
    run_op("R3", MAXV, MAXV, NEG1, 1'b0);          // above range
    run_op("R3", MAXV, MAXV, MINV, 1'b0);          // 2^63-2, fits
    run_op("R3", MAXV, MINV, 64'd1, 1'b0);         // cancels to 0
    run_op("R3", MAXV, 64'd1, 64'd0, 1'b0);        // exactly 2^63
    run_op("R3", MINV, NEG1, 64'd0, 1'b0);         // exactly -2^63-1
    run_op("R3", MAXV, 64'd1, NEG1, 1'b0);         // transient excursion, fits
    run_op("R3", MINV, 64'd0, 64'd0, 1'b0);        // lower edge, fits
  endtask

  task automatic t_two_op;
    run_op("R4", 64'd100, 64'd23, MAXV, 1'b1);
    run_op("R4", MAXV, 64'd0, MAXV, 1'b1);         // c would overflow
    run_op("R5", MAXV, 64'd1, 64'd0, 1'b1);
    run_op("R5", MINV, MINV, 64'd0, 1'b1);
    run_op("R5", MAXV, MINV, NEG1, 1'b1);
    run_op("R5", NEG1, NEG1, 64'd0, 1'b1);
  endtask

  task automatic t_latency;
    run_op("R6", 64'd1, 64'd2, 64'd3, 1'b0);
    @(negedge clk);
    check("R6", "out_valid drops", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_hold;
    logic [W-1:0] es;
    logic eo;
    run_op("R7", MAXV, MAXV, MAXV, 1'b0);
    expect_of(MAXV, MAXV, MAXV, 1'b0, es, eo);
    op_a = 64'd0; op_b = 64'd0; op_c = 64'd0; two_op = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", "sum held", sum, es);
    check("R7", "ovf held", {63'd0, ovf}, {63'd0, eo});
  endtask

  task automatic t_order;
    logic [W-1:0] x, y, z, s0;
    logic o0;
    x = MAXV; y = 64'hC000_0000_0000_0000; z = 64'h4000_0000_0000_0001;
    run_op("R8", x, y, z, 1'b0);
    s0 = sum; o0 = ovf;
    run_op("R8", z, x, y, 1'b0);
    check("R8", "permuted sum", sum, s0);
    check("R8", "permuted ovf", {63'd0, ovf}, {63'd0, o0});
    run_op("R8", y, z, x, 1'b0);
    check("R8", "permuted sum", sum, s0);
  endtask

  initial begin
    t_reset();
    t_three_sum();
    t_three_ovf();
    t_two_op();
    t_latency();
    t_hold();
    t_order();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule